// File: doc/BRIEF.md
# PWM Period Parameter Search Engine

This block turns a requested PWM period, given in microseconds, into the four settings a PWM timer needs: the counter size (6 or 9 bits), the reference clock, the pre-divide code and the power-of-two exponent. The combination it chooses is the one whose per-step duration comes closest to the requested period divided by the counter length. A duty time is taken with the request for validation only. Computing the duty value and writing timer registers are left to other logic.

A request is accepted with a single-cycle `start` pulse while the block is idle. The block first rejects requests that are out of range. For a valid request it scales the period to nanoseconds and divides it by the counter length. It then walks a fixed table of per-step durations and evaluates one candidate per clock. It keeps the candidate with the smallest absolute error. The scan over exponents for a given clock and pre-divide pair stops early as soon as the error starts to grow. When the scan ends, `done` pulses for one cycle. The chosen fields, or an error flag, stay on the outputs until the next accepted request.

Top module: `pwm_period_search`

## Requirements
- R1: A request is rejected when duty exceeds period, when period is below 7 us, or when period is above 384,000,000 us. A rejected request ends with `done` and `err` high and `size9`, `clk_code`, `div_code` and `exp_m` all 0, two clock edges after the accepting edge.
- R2: Both range ends are valid: period 7 us and period 384,000,000 us are accepted, and duty equal to period is accepted.
- R3: The target step time is (period_us * 1000) >> 6 nanoseconds, computed without overflow. If this is at least 749,999,616, then `size9` is 1 and the target is shifted right by a further 3. Otherwise `size9` is 0.
- R4: Clock codes are 0 = 1024 Hz (976,562 ns), 1 = 32,768 Hz (30,517 ns) and 2 = 19.2 MHz (52 ns). Pre-divide codes 0..3 mean factors 1, 3, 5 and 6. The base duration of a pair is factor times the clock period in nanoseconds, and exponent m doubles it m times (m = 0..7).
- R5: Candidates are scanned with the clock code outermost, then the pre-divide code, then m ascending. The best is replaced only by a strictly smaller absolute error, so a tie keeps the earlier candidate.
- R6: For m > 0, the exponent scan of a pair ends at the first candidate whose error exceeds the previous candidate's error. That candidate still counts as evaluated. The previous-error register starts at all ones once per search. One candidate is evaluated per cycle, so a valid search reports `done` N+2 edges after the accepting edge, where N is the number of candidates evaluated.
- R7: `start` is accepted only while `busy` is low, and `busy` is high on the following cycle. `done` is a one-cycle pulse with `busy` low. A `start` while busy has no effect.
- R8: After reset, `busy`, `done`, `err` and all result fields are 0. The result fields and `err` hold their values until the next accepted request completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request pulse, taken while idle |
| period_us | input | 32 | Requested PWM period in microseconds |
| duty_us | input | 32 | Requested duty time in microseconds (validation only) |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last request was rejected |
| size9 | output | 1 | 1 = 9-bit counter, 0 = 6-bit counter |
| clk_code | output | 2 | Chosen reference clock code |
| div_code | output | 2 | Chosen pre-divide code |
| exp_m | output | 3 | Chosen exponent |

## Verification
The bench builds the block with its default widths. These are a 32-bit request, a 48-bit nanosecond product and a 32-bit target. With them the full 7 to 384,000,000 us range is legal input, so the bench can drive both range ends, their out-of-range neighbours, and the pair of periods 47,999,975 and 47,999,976 us that straddle the 6-to-9-bit switch. Each request is compared field by field with a behavioural model of the same search. The check also covers the cycle count to `done`, which exposes any change in where the early exit of the exponent scan fires.

// File: rtl/pwm_solve_pkg.sv
// Package: shared constants, lookup functions and types of the PWM period search.
// Assumes the clock list is ordered slowest first, so entry 0 sets the size threshold.
package pwm_solve_pkg;

    localparam int NUM_CLK = 3;
    localparam int NUM_DIV = 4;
    localparam int M_MAX   = 7;

    localparam int CLK_W = $clog2(NUM_CLK);
    localparam int DIV_W = $clog2(NUM_DIV);
    localparam int M_W   = $clog2(M_MAX + 1);

    localparam int TICK_SHIFT = 6;   // 6-bit counter length as a shift
    localparam int WIDE_SHIFT = 3;   // extra shift for the 9-bit counter

    // Truncated nanosecond period of each reference clock.
    function automatic longint clk_period_ns(input int idx);
        case (idx)
            0:       return 64'd1000000000 / 64'd1024;
            1:       return 64'd1000000000 / 64'd32768;
            default: return 64'd1000000000 / 64'd19200000;
        endcase
    endfunction

    // Division factor behind each pre-divide code.
    function automatic longint div_factor(input int code);
        case (code)
            0:       return 64'd1;
            1:       return 64'd3;
            2:       return 64'd5;
            default: return 64'd6;
        endcase
    endfunction

    // Largest reachable step time; targets at or above it need the 9-bit counter.
    localparam longint SIZE_THRESH = (div_factor(NUM_DIV - 1) * clk_period_ns(0)) << M_MAX;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PREP,
        ST_RUN
    } search_state_t;

    typedef struct packed {
        logic             size9;
        logic [CLK_W-1:0] clk_code;
        logic [DIV_W-1:0] div_code;
        logic [M_W-1:0]   exp_m;
    } pick_t;

endpackage

// File: rtl/pwm_req_prep.sv
// Module: request checker and target scaler.
// Checks the latched request against the range limits. Converts the period to
// nanoseconds in a product wide enough not to overflow, divides it by the counter
// length and picks the counter size. Purely combinational.
module pwm_req_prep
    import pwm_solve_pkg::*;
#(
    parameter int     PERIOD_W = 32,
    parameter int     NS_W     = 48,
    parameter int     TGT_W    = 32,
    parameter longint MIN_US   = 7,
    parameter longint MAX_US   = 384000000
) (
    input  logic [PERIOD_W-1:0] period_us,
    input  logic [PERIOD_W-1:0] duty_us,
    output logic                req_ok,
    output logic [TGT_W-1:0]    target,
    output logic                size9
);

    localparam logic [NS_W-1:0] NS_PER_US = NS_W'(1000);
    localparam logic [NS_W-1:0] THRESH    = NS_W'(SIZE_THRESH);

    logic [NS_W-1:0] period_ns;
    logic [NS_W-1:0] step_ns;

    // Range and ordering checks on the request.
    always_comb begin : range_check
        req_ok = (duty_us <= period_us)
              && (NS_W'(period_us) >= NS_W'(MIN_US))
              && (NS_W'(period_us) <= NS_W'(MAX_US));
    end

    // Scale to nanoseconds per counter step and choose the counter size.
    always_comb begin : scale
        period_ns = NS_W'(period_us) * NS_PER_US;
        step_ns   = period_ns >> TICK_SHIFT;
        size9     = (step_ns >= THRESH);
        target    = TGT_W'(size9 ? (step_ns >> WIDE_SHIFT) : step_ns);
    end

endmodule

// File: rtl/pwm_tick_table.sv
// Module: table of base step durations.
// Holds one constant per (clock, pre-divide) pair, equal to the factor times the
// clock period in ns. Returns the entry addressed by the select inputs, or 0 for
// an unused clock code.
module pwm_tick_table
    import pwm_solve_pkg::*;
#(
    parameter int TGT_W = 32
) (
    input  logic [CLK_W-1:0] sel_clk,
    input  logic [DIV_W-1:0] sel_div,
    output logic [TGT_W-1:0] base
);

    logic [TGT_W-1:0] tbl [NUM_CLK][NUM_DIV];

    for (genvar gc = 0; gc < NUM_CLK; gc++) begin : g_clk
        for (genvar gd = 0; gd < NUM_DIV; gd++) begin : g_div
            localparam longint ENTRY = clk_period_ns(gc) * div_factor(gd);
            assign tbl[gc][gd] = TGT_W'(ENTRY);
        end
    end

    // Read the addressed entry.
    always_comb begin : lookup
        base = '0;
        for (int c = 0; c < NUM_CLK; c++) begin
            for (int d = 0; d < NUM_DIV; d++) begin
                if (sel_clk == CLK_W'(c) && sel_div == DIV_W'(d)) begin
                    base = tbl[c][d];
                end
            end
        end
    end

endmodule

// File: rtl/pwm_err_eval.sv
// Module: candidate error evaluator.
// Forms the absolute difference between target and candidate. Flags when it beats
// the best so far (strictly), and when it grows over the previous step's error on
// a step other than the first of a pair. Purely combinational.
module pwm_err_eval #(
    parameter int TGT_W = 32
) (
    input  logic [TGT_W-1:0] target,
    input  logic [TGT_W-1:0] cand,
    input  logic [TGT_W-1:0] best_err,
    input  logic [TGT_W-1:0] prev_err,
    input  logic             first_step,
    output logic [TGT_W-1:0] cur_err,
    output logic             better,
    output logic             rising
);

    // Absolute difference and the two comparisons.
    always_comb begin : judge
        cur_err = (target > cand) ? (target - cand) : (cand - target);
        better  = (cur_err < best_err);
        rising  = !first_step && (cur_err > prev_err);
    end

endmodule

// File: rtl/pwm_period_search.sv
// Module: top of the PWM period parameter search.
// Takes a request on start while idle. Spends one cycle on validation and scaling,
// then evaluates one candidate per cycle in clock / pre-divide / exponent order, and
// pulses done with the chosen fields or the error flag. Results hold until the
// next accepted request completes. Requests arriving while busy are dropped.
module pwm_period_search
    import pwm_solve_pkg::*;
#(
    parameter int     PERIOD_W = 32,
    parameter int     NS_W     = 48,
    parameter int     TGT_W    = 32,
    parameter longint MIN_US   = 7,
    parameter longint MAX_US   = 384000000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [PERIOD_W-1:0] period_us,
    input  logic [PERIOD_W-1:0] duty_us,
    output logic                busy,
    output logic                done,
    output logic                err,
    output logic                size9,
    output logic [CLK_W-1:0]    clk_code,
    output logic [DIV_W-1:0]    div_code,
    output logic [M_W-1:0]      exp_m
);

    localparam logic [CLK_W-1:0] LAST_CLK = CLK_W'(NUM_CLK - 1);
    localparam logic [DIV_W-1:0] LAST_DIV = DIV_W'(NUM_DIV - 1);
    localparam logic [M_W-1:0]   LAST_M   = M_W'(M_MAX);

    search_state_t       state;
    logic [PERIOD_W-1:0] req_period;
    logic [PERIOD_W-1:0] req_duty;
    logic [TGT_W-1:0]    target;
    logic                tgt_size9;
    logic [CLK_W-1:0]    ci;
    logic [DIV_W-1:0]    di;
    logic [M_W-1:0]      mi;
    logic [TGT_W-1:0]    cand;
    logic [TGT_W-1:0]    min_err;
    logic [TGT_W-1:0]    last_err;
    pick_t               best;
    pick_t               result;

    logic                prep_ok;
    logic [TGT_W-1:0]    prep_target;
    logic                prep_size9;
    logic [CLK_W-1:0]    sel_c;
    logic [DIV_W-1:0]    sel_d;
    logic [TGT_W-1:0]    table_base;
    logic [TGT_W-1:0]    cur_err;
    logic                better;
    logic                rising;
    logic                pair_end;
    logic                last_pair;
    pick_t               pick_now;

    pwm_req_prep #(
        .PERIOD_W (PERIOD_W),
        .NS_W     (NS_W),
        .TGT_W    (TGT_W),
        .MIN_US   (MIN_US),
        .MAX_US   (MAX_US)
    ) u_prep (
        .period_us (req_period),
        .duty_us   (req_duty),
        .req_ok    (prep_ok),
        .target    (prep_target),
        .size9     (prep_size9)
    );

    pwm_tick_table #(
        .TGT_W (TGT_W)
    ) u_table (
        .sel_clk (sel_c),
        .sel_div (sel_d),
        .base    (table_base)
    );

    pwm_err_eval #(
        .TGT_W (TGT_W)
    ) u_eval (
        .target     (target),
        .cand       (cand),
        .best_err   (min_err),
        .prev_err   (last_err),
        .first_step (mi == '0),
        .cur_err    (cur_err),
        .better     (better),
        .rising     (rising)
    );

    // Address of the next pair to load: the first pair in prep, else the successor.
    always_comb begin : next_pair
        sel_c = ci;
        sel_d = di;
        if (state == ST_PREP) begin
            sel_c = '0;
            sel_d = '0;
        end else if (di == LAST_DIV) begin
            sel_c = ci + 1'b1;
            sel_d = '0;
        end else begin
            sel_d = di + 1'b1;
        end
    end

    // End-of-pair, end-of-scan and the best pick including this cycle's candidate.
    always_comb begin : scan_status
        pair_end  = (mi == LAST_M) || rising;
        last_pair = (ci == LAST_CLK) && (di == LAST_DIV);
        pick_now  = best;
        if (better) begin
            pick_now.clk_code = ci;
            pick_now.div_code = di;
            pick_now.exp_m    = mi;
        end
        pick_now.size9 = tgt_size9;
    end

    // Control sequence: accept, validate and scale, scan, report.
    always_ff @(posedge clk) begin : seq
        if (!rst_n) begin
            state      <= ST_IDLE;
            req_period <= '0;
            req_duty   <= '0;
            target     <= '0;
            tgt_size9  <= 1'b0;
            ci         <= '0;
            di         <= '0;
            mi         <= '0;
            cand       <= '0;
            min_err    <= '1;
            last_err   <= '1;
            best       <= '0;
            result     <= '0;
            done       <= 1'b0;
            err        <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        req_period <= period_us;
                        req_duty   <= duty_us;
                        state      <= ST_PREP;
                    end
                end
                ST_PREP: begin
                    if (!prep_ok) begin
                        state  <= ST_IDLE;
                        done   <= 1'b1;
                        err    <= 1'b1;
                        result <= '0;
                    end else begin
                        target    <= prep_target;
                        tgt_size9 <= prep_size9;
                        ci        <= '0;
                        di        <= '0;
                        mi        <= '0;
                        cand      <= table_base;
                        min_err   <= '1;
                        last_err  <= '1;
                        best      <= '0;
                        state     <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (better) begin
                        min_err <= cur_err;
                    end
                    best <= pick_now;
                    if (!rising) begin
                        last_err <= cur_err;
                    end
                    if (pair_end) begin
                        if (last_pair) begin
                            state  <= ST_IDLE;
                            done   <= 1'b1;
                            err    <= 1'b0;
                            result <= pick_now;
                        end else begin
                            ci   <= sel_c;
                            di   <= sel_d;
                            mi   <= '0;
                            cand <= table_base;
                        end
                    end else begin
                        mi   <= mi + 1'b1;
                        cand <= cand << 1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Output mapping.
    always_comb begin : outs
        busy     = (state != ST_IDLE);
        size9    = result.size9;
        clk_code = result.clk_code;
        div_code = result.div_code;
        exp_m    = result.exp_m;
    end

endmodule

// File: rtl/pwm_period_search_chk.sv
// Module: protocol checker for pwm_period_search, attached with bind.
// Observes the handshake and result ports only.
module pwm_period_search_chk
    import pwm_solve_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic             err,
    input logic             size9,
    input logic [CLK_W-1:0] clk_code,
    input logic [DIV_W-1:0] div_code,
    input logic [M_W-1:0]   exp_m
);

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                   // R7
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);                                                   // R7
    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));                                             // R7
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);                                        // R7
    AST_REJECT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> (!size9 && clk_code == '0 && div_code == '0 && exp_m == '0)); // R1
    AST_CLK_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> (clk_code < CLK_W'(NUM_CLK)));                  // R4
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable({err, size9, clk_code, div_code, exp_m})); // R8

endmodule

bind pwm_period_search pwm_period_search_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .err      (err),
    .size9    (size9),
    .clk_code (clk_code),
    .div_code (div_code),
    .exp_m    (exp_m)
);

// File: tb/pwm_period_search_test.sv
// Scoreboard bench: the driver models each request and queues the expectation,
// the monitor compares on every done pulse.
module pwm_period_search_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] period_us = '0;
    logic [31:0] duty_us = '0;
    logic        busy, done, err, size9;
    logic [1:0]  clk_code, div_code;
    logic [2:0]  exp_m;

    always #4 clk = ~clk;   // 125 MHz

    pwm_period_search uut (
        .clk(clk), .rst_n(rst_n), .start(start), .period_us(period_us), .duty_us(duty_us),
        .busy(busy), .done(done), .err(err), .size9(size9),
        .clk_code(clk_code), .div_code(div_code), .exp_m(exp_m)
    );

    typedef struct {
        logic   err;
        logic   size9;
        int     c;
        int     d;
        int     m;
        longint lat;
        longint sc;
    } exp_t;

    exp_t   sb[$];
    exp_t   mon_e;
    exp_t   last_e;
    int     checks = 0;
    int     errors = 0;
    longint cyc = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string what, input longint got, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", what, got, expv);
        end
    endtask

    // Behavioural model of the search (R1..R6).
    function automatic exp_t model(input longint p, input longint d);
        exp_t   e;
        longint base_ns [3] = '{976562, 30517, 52};
        longint fac [4]     = '{1, 3, 5, 6};
        longint tgt, t, cur, minerr, lasterr;
        int     n;
        e = '{err: 1'b0, size9: 1'b0, c: 0, d: 0, m: 0, lat: 0, sc: 0};
        if (d > p || p < 7 || p > 384000000) begin
            e.err = 1'b1;
            e.lat = 2;
            return e;
        end
        tgt = (p * 1000) >>> 6;
        if (tgt >= 749999616) begin
            e.size9 = 1'b1;
            tgt = tgt >>> 3;
        end
        minerr  = 64'hFFFF_FFFF;
        lasterr = 64'hFFFF_FFFF;
        n = 0;
        for (int c = 0; c < 3; c++) begin
            for (int dv = 0; dv < 4; dv++) begin
                t = base_ns[c] * fac[dv];
                for (int m = 0; m <= 7; m++) begin
                    n++;
                    cur = (tgt > t) ? tgt - t : t - tgt;
                    if (cur < minerr) begin
                        minerr = cur; e.c = c; e.d = dv; e.m = m;
                    end
                    if (m > 0 && cur > lasterr) break;
                    lasterr = cur;
                    t = t << 1;
                end
            end
        end
        e.lat = n + 2;
        return e;
    endfunction

    // Driver: model, queue, pulse start; optionally fire a start while busy (R7).
    task automatic run_req(input longint p, input longint d, input bit poke);
        exp_t e;
        while (busy) @(negedge clk);
        e = model(p, d);
        period_us = 32'(p);
        duty_us   = 32'(d);
        e.sc = cyc;
        sb.push_back(e);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R7 busy after accept", longint'(busy), 1);
        if (poke) begin
            period_us = 32'd12345;
            duty_us   = 32'd1;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (sb.size() != 0) @(negedge clk);
        last_e = e;
        repeat (4) @(negedge clk);
        chk(err == e.err && size9 == e.size9 && int'(clk_code) == e.c &&
            int'(div_code) == e.d && int'(exp_m) == e.m,
            "R8 result held after done", longint'({err, size9, clk_code, div_code, exp_m}),
            longint'({e.err, e.size9, 2'(e.c), 2'(e.d), 3'(e.m)}));
    endtask

    // Monitor: compare on every done pulse.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R7 done with no accepted request", 1, 0);
            end else begin
                mon_e = sb.pop_front();
                chk(err == mon_e.err, "R1 err flag", longint'(err), longint'(mon_e.err));
                chk(size9 == mon_e.size9, "R3 size9", longint'(size9), longint'(mon_e.size9));
                chk(int'(clk_code) == mon_e.c, "R4 clk_code", longint'(clk_code), mon_e.c);
                chk(int'(div_code) == mon_e.d, "R4 div_code", longint'(div_code), mon_e.d);
                chk(int'(exp_m) == mon_e.m, "R5 exp_m", longint'(exp_m), mon_e.m);
                chk(cyc - mon_e.sc == mon_e.lat, "R6 latency", cyc - mon_e.sc, mon_e.lat);
                chk(busy == 1'b0, "R7 busy low with done", longint'(busy), 0);
            end
        end
    end

    // Done must drop after one cycle (R7).
    always @(negedge clk) begin
        if (rst_n && done) begin
            @(negedge clk);
            chk(done == 1'b0, "R7 done single cycle", longint'(done), 0);
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired: got 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        longint p;
        repeat (4) @(negedge clk);
        chk({busy, done, err, size9, clk_code, div_code, exp_m} == '0, "R8 reset state",
            longint'({busy, done, err, size9, clk_code, div_code, exp_m}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "R8 idle after reset", longint'({busy, done}), 0);

        // R1 rejections
        run_req(1000, 1001, 1'b0);
        run_req(6, 3, 1'b0);
        run_req(384000001, 10, 1'b0);
        // R2 range ends and duty equal to period
        run_req(7, 7, 1'b0);
        run_req(384000000, 1, 1'b0);
        // R3 size switch neighbours
        run_req(47999975, 100, 1'b0);
        run_req(47999976, 100, 1'b0);
        // R4/R5/R6 assorted periods
        run_req(20, 10, 1'b0);
        run_req(1000, 500, 1'b0);
        run_req(20000, 0, 1'b0);
        run_req(1000000, 400000, 1'b0);
        run_req(65536, 100, 1'b0);
        // R7 start while busy has no effect
        run_req(3333, 1000, 1'b1);
        run_req(250000000, 5, 1'b1);
        // random periods over several decades
        for (int i = 0; i < 40; i++) begin
            p = longint'($urandom_range(1000, 7)) << $urandom_range(18, 0);
            if (p > 384000000) p = 384000000;
            run_req(p, p / 3, 1'b0);
        end
        for (int i = 0; i < 10; i++) begin
            p = longint'($urandom_range(384000000, 7));
            run_req(p, p, 1'b0);
        end
        repeat (5) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule